// File: doc/BRIEF.md
# TDM Bit-Clock and Frame-Sync Generator

This block is the timing master of a short-frame serial time-division link. From a single fast system clock it derives a bit clock at one of three rates. It also produces a frame sync that repeats at 8 kHz whatever rate is selected. No derived clock is created. The bit clock is a registered-state output, and two one-cycle strobes (`bitRise`, `bitFall`) mark its edges so that neighbouring shift logic can run on the system clock.

The sync is an active-high pulse exactly one bit period wide, and it starts on a rising edge of the bit clock. It occupies the last bit of each frame, so it precedes the first data bit by one bit. With the default parameters the system clock is 30.72 MHz. The three rates then divide it by 20, 15 and 12, and every frame lasts 3840 system cycles.

A new rate is taken only when a sync bit begins, so no frame is cut short. While network timing is absent (`netLock` low), `freeRun` decides whether syncs keep being issued or are held low. While timing is present, a `realign` pulse restarts the frame phase at once. The `REDUCED` parameter removes the slowest rate: in that case code 00 selects the middle rate.

Top module: `tdm_sync_gen`

## Requirements
- R1: While `rstN` is low, `frameSync`, `bitClk`, `bitRise` and `bitFall` are all low. After reset is released, the first sync is high in the cycle that follows the first clock edge with `rstN` high, and it uses the rate then on `rateSel`.
- R2: `rateSel` codes: 00 gives a 20-cycle bit period and 192-bit frame (1.536 MHz); 01 and 11 give 15 cycles and 256 bits (2.048 MHz); 10 gives 12 cycles and 320 bits (2.56 MHz).
- R3: Each sync lasts exactly one bit period (the divider of its frame's rate). It rises in the same cycle as `bitRise`, with `bitClk` high.
- R4: Without realignment, consecutive sync rises are BITS×DIV system cycles apart, which is 3840 cycles for every rate with the default parameters.
- R5: A change on `rateSel` takes effect only when a sync bit begins. Every frame then holds the full bit count of its own rate.
- R6: `bitRise` and `bitFall` are one-cycle strobes that are never high together. `bitClk` is high for floor(DIV/2) cycles, starting in the `bitRise` cycle.
- R7: Whether a sync is issued is decided when its sync bit begins: it is issued if `netLock` or `freeRun` is high, and otherwise that frame's sync stays low. The bit clock keeps running either way.
- R8: A `realign` pulse sampled with `netLock` high restarts the frame. The sync goes high in the next cycle at the rate currently on `rateSel`.
- R9: A `realign` pulse sampled with `netLock` low has no effect on the frame phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 2 | Bit-rate select code |
| netLock | input | 1 | Network timing present |
| freeRun | input | 1 | Keep issuing syncs while timing is absent |
| realign | input | 1 | Restart the frame phase (honoured only with timing present) |
| bitClk | output | 1 | Bit clock level |
| bitRise | output | 1 | One-cycle strobe on each bit-clock rising edge |
| bitFall | output | 1 | One-cycle strobe on each bit-clock falling edge |
| frameSync | output | 1 | One-bit-wide frame sync |

## Verification
Several properties are checked on every cycle:
- the two edge strobes are mutually exclusive;
- the counters stay inside the limits of the active rate;
- a sync only ever sits on the last bit of a frame and starts with a bit-clock rise;
- the active rate never changes outside a frame restart;
- an unlocked realign never forces a restart.

Other behaviour only the bench scenarios can show:
- the real spacing and width of syncs across rate changes;
- the bit count of each frame;
- frames suppressed when free-run is off;
- the phase jump after a locked realign, compared with an ignored unlocked one.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;

  // Active rate index held by the control
  typedef enum logic [1:0] {
    IDX_SLOW = 2'd0,
    IDX_MID  = 2'd1,
    IDX_FAST = 2'd2
  } rateIdx_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;  // enter the sync bit now (frame boundary or realign)
    logic step;     // current bit period ends this cycle
    logic gate;     // sync allowed for the frame being entered
  } tdmStrobe_t;

endpackage

// File: rtl/tdm_sync_ctrl.sv
module tdm_sync_ctrl
  import tdm_sync_pkg::*;
#(
  parameter int DIV_SLOW  = 20,
  parameter int DIV_MID   = 15,
  parameter int DIV_FAST  = 12,
  parameter int BITS_SLOW = 192,
  parameter int BITS_MID  = 256,
  parameter int BITS_FAST = 320,
  parameter bit REDUCED   = 1'b0,
  parameter int DW        = 5,
  parameter int BW        = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       rateSel,
  input  logic             netLock,
  input  logic             freeRun,
  input  logic             realign,
  input  logic             divLast,
  input  logic             bitPenult,
  output tdmStrobe_t       strobe,
  output logic [DW-1:0]    curDiv,
  output logic [BW-1:0]    curBits,
  output logic [BW-1:0]    nextBits
);

  rateIdx_e rateQ;
  rateIdx_e rateD;
  logic     boundary;
  logic     lockedRealign;

  function automatic rateIdx_e decodeSel(input logic [1:0] sel);
    case (sel)
      2'b00:   return REDUCED ? IDX_MID : IDX_SLOW;
      2'b10:   return IDX_FAST;
      default: return IDX_MID;
    endcase
  endfunction

  function automatic logic [DW-1:0] divOf(input rateIdx_e idx);
    case (idx)
      IDX_SLOW: return DW'(DIV_SLOW);
      IDX_FAST: return DW'(DIV_FAST);
      default:  return DW'(DIV_MID);
    endcase
  endfunction

  function automatic logic [BW-1:0] bitsOf(input rateIdx_e idx);
    case (idx)
      IDX_SLOW: return BW'(BITS_SLOW);
      IDX_FAST: return BW'(BITS_FAST);
      default:  return BW'(BITS_MID);
    endcase
  endfunction

  always_comb begin
    rateD          = decodeSel(rateSel);
    boundary       = divLast && bitPenult;
    lockedRealign  = realign && netLock;
    strobe.restart = boundary || lockedRealign;
    strobe.step    = divLast;
    strobe.gate    = netLock || freeRun;
    curDiv         = divOf(rateQ);
    curBits        = bitsOf(rateQ);
    nextBits       = bitsOf(rateD);
  end

  // Rate is only ever loaded when a sync bit begins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= IDX_MID;
    end else if (strobe.restart) begin
      rateQ <= rateD;
    end
  end

  // R5: the active rate is held between frame restarts
  a_r5_rate_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |=> $stable(rateQ));

  // R9: an unlocked realign away from a boundary never restarts the frame
  a_r9_unlocked_realign: assert property (@(posedge clk) disable iff (!rstN)
    (realign && !netLock && !(divLast && bitPenult)) |-> !strobe.restart);

endmodule

// File: rtl/tdm_sync_dp.sv
module tdm_sync_dp
  import tdm_sync_pkg::*;
#(
  parameter int DW       = 5,
  parameter int BW       = 9,
  parameter int RST_DIV  = 15,
  parameter int RST_BITS = 256
) (
  input  logic          clk,
  input  logic          rstN,
  input  tdmStrobe_t    strobe,
  input  logic [DW-1:0] curDiv,
  input  logic [BW-1:0] curBits,
  input  logic [BW-1:0] nextBits,
  output logic          divLast,
  output logic          bitPenult,
  output logic          bitClk,
  output logic          bitRise,
  output logic          bitFall,
  output logic          frameSync
);

  logic [DW-1:0] divCnt;
  logic [BW-1:0] bitCnt;
  logic [DW-1:0] halfDiv;
  logic          bitLast;

  always_comb begin
    halfDiv   = curDiv >> 1;
    divLast   = (divCnt == curDiv - DW'(1));
    bitPenult = (bitCnt == curBits - BW'(2));
    bitLast   = (bitCnt == curBits - BW'(1));
    bitRise   = (divCnt == '0);
    bitFall   = (divCnt == halfDiv);
    bitClk    = (divCnt < halfDiv);
  end

  // Reset parks the counters one cycle before a frame boundary,
  // so the first edge after reset enters the sync bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= DW'(RST_DIV - 1);
      bitCnt    <= BW'(RST_BITS - 2);
      frameSync <= 1'b0;
    end else if (strobe.restart) begin
      divCnt    <= '0;
      bitCnt    <= nextBits - BW'(1);
      frameSync <= strobe.gate;
    end else if (strobe.step) begin
      divCnt    <= '0;
      bitCnt    <= bitLast ? '0 : bitCnt + BW'(1);
      frameSync <= 1'b0;
    end else begin
      divCnt    <= divCnt + DW'(1);
    end
  end

  // R3: a sync begins together with a bit-clock rise
  a_r3_sync_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |-> (bitRise && bitClk));

  // R3: the sync only ever occupies the last bit of a frame
  a_r3_sync_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> (bitCnt == curBits - BW'(1)));

  // R6: edge strobes never coincide
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(bitRise && bitFall));

  // R5: counters stay inside the active rate's limits
  a_r5_counter_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt < curBits) && (divCnt < curDiv));

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
  import tdm_sync_pkg::*;
#(
  parameter int DIV_SLOW  = 20,
  parameter int DIV_MID   = 15,
  parameter int DIV_FAST  = 12,
  parameter int BITS_SLOW = 192,
  parameter int BITS_MID  = 256,
  parameter int BITS_FAST = 320,
  parameter bit REDUCED   = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       netLock,
  input  logic       freeRun,
  input  logic       realign,
  output logic       bitClk,
  output logic       bitRise,
  output logic       bitFall,
  output logic       frameSync
);

  localparam int MAX_DIV_A = (DIV_SLOW > DIV_MID) ? DIV_SLOW : DIV_MID;
  localparam int MAX_DIV   = (MAX_DIV_A > DIV_FAST) ? MAX_DIV_A : DIV_FAST;
  localparam int MAX_BIT_A = (BITS_SLOW > BITS_MID) ? BITS_SLOW : BITS_MID;
  localparam int MAX_BITS  = (MAX_BIT_A > BITS_FAST) ? MAX_BIT_A : BITS_FAST;
  localparam int DW        = $clog2(MAX_DIV + 1);
  localparam int BW        = $clog2(MAX_BITS + 1);

  tdmStrobe_t    strobe;
  logic [DW-1:0] curDiv;
  logic [BW-1:0] curBits;
  logic [BW-1:0] nextBits;
  logic          divLast;
  logic          bitPenult;

  tdm_sync_ctrl #(
    .DIV_SLOW (DIV_SLOW),  .DIV_MID (DIV_MID),  .DIV_FAST (DIV_FAST),
    .BITS_SLOW(BITS_SLOW), .BITS_MID(BITS_MID), .BITS_FAST(BITS_FAST),
    .REDUCED  (REDUCED),   .DW      (DW),       .BW       (BW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .netLock  (netLock),
    .freeRun  (freeRun),
    .realign  (realign),
    .divLast  (divLast),
    .bitPenult(bitPenult),
    .strobe   (strobe),
    .curDiv   (curDiv),
    .curBits  (curBits),
    .nextBits (nextBits)
  );

  tdm_sync_dp #(
    .DW(DW), .BW(BW), .RST_DIV(DIV_MID), .RST_BITS(BITS_MID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curDiv   (curDiv),
    .curBits  (curBits),
    .nextBits (nextBits),
    .divLast  (divLast),
    .bitPenult(bitPenult),
    .bitClk   (bitClk),
    .bitRise  (bitRise),
    .bitFall  (bitFall),
    .frameSync(frameSync)
  );

endmodule

// File: tb/sim_tdm_sync_gen.sv
module sim_tdm_sync_gen;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] rateSel;
  logic       netLock;
  logic       freeRun;
  logic       realign;
  logic       bitClk;
  logic       bitRise;
  logic       bitFall;
  logic       frameSync;

  always #5 clk = ~clk;

  tdm_sync_gen u0 (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .netLock(netLock),
    .freeRun(freeRun), .realign(realign), .bitClk(bitClk),
    .bitRise(bitRise), .bitFall(bitFall), .frameSync(frameSync)
  );

  typedef struct {
    int    interval;  // cycles since previous sync rise, -1 = don't care
    int    bits;      // bit rises since previous sync rise, -1 = don't care
    int    width;     // sync length in cycles (bit period)
    int    hi;        // bitClk high cycles inside the sync
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expectSync(input int interval, input int bits,
                            input int width, input string tag);
    expItem_t it;
    it.interval = interval;
    it.bits     = bits;
    it.width    = width;
    it.hi       = width / 2;
    it.tag      = tag;
    expQ.push_back(it);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // Monitor: pops one expectation per observed sync rise
  initial begin
    int       cyc = 0;
    int       lastRise = 0;
    int       riseCnt = 0;
    int       wid = 0;
    int       hi = 0;
    bit       prevSync = 1'b0;
    bit       inSync = 1'b0;
    expItem_t cur;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (frameSync && !prevSync) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R7", "unexpected sync rise", cyc, -1);
          end else begin
            cur = expQ.pop_front();
            inSync = 1'b1;
            if (cur.interval >= 0)
              check(cyc - lastRise == cur.interval, cur.tag, "sync interval",
                    cyc - lastRise, cur.interval);
            if (cur.bits >= 0)
              check(riseCnt == cur.bits, cur.tag, "bits in frame",
                    riseCnt, cur.bits);
            check(bitRise && bitClk, "R3", "bit clock rise with sync",
                  int'(bitRise && bitClk), 1);
          end
          lastRise = cyc;
          riseCnt  = 0;
          wid      = 0;
          hi       = 0;
        end
        if (bitRise) riseCnt++;
        if (frameSync) begin
          wid++;
          if (bitClk) hi++;
        end
        if (!frameSync && prevSync && inSync) begin
          inSync = 1'b0;
          check(wid == cur.width, cur.tag, "sync width", wid, cur.width);
          check(hi == cur.hi, "R6", "bitClk high cycles", hi, cur.hi);
        end
      end
      prevSync = frameSync;
    end
  end

  // Driver
  initial begin
    int highCnt;
    int riseSeen;
    rstN    = 1'b0;
    rateSel = 2'b01;
    netLock = 1'b1;
    freeRun = 1'b0;
    realign = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(frameSync == 1'b0, "R1", "frameSync in reset", int'(frameSync), 0);
    check(bitClk == 1'b0, "R1", "bitClk in reset", int'(bitClk), 0);
    check(bitRise == 1'b0, "R1", "bitRise in reset", int'(bitRise), 0);
    check(bitFall == 1'b0, "R1", "bitFall in reset", int'(bitFall), 0);

    expectSync(-1, -1, 15, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(frameSync == 1'b1, "R1", "sync after first edge", int'(frameSync), 1);

    // R5/R2: rate change mid-frame applies at the next sync bit
    rateSel = 2'b10;
    expectSync(3840, 256, 12, "R5");
    @(posedge frameSync);
    rateSel = 2'b00;
    expectSync(3840, 320, 20, "R2");
    @(posedge frameSync);
    rateSel = 2'b11;
    expectSync(3840, 192, 15, "R2");
    @(posedge frameSync);

    // R8: locked realign 1000 cycles into the frame, new rate taken at once
    expectSync(1000, -1, 12, "R8");
    repeat (1000) @(negedge clk);
    realign = 1'b1;
    rateSel = 2'b10;
    @(negedge clk);
    realign = 1'b0;

    // R4: full frame follows the realigned sync; timing lost but free-running
    expectSync(3840, 320, 12, "R4");
    netLock = 1'b0;
    freeRun = 1'b1;
    @(posedge frameSync);

    // R9: unlocked realign is ignored
    expectSync(3840, 320, 12, "R9");
    repeat (1000) @(negedge clk);
    realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;
    check(frameSync == 1'b0, "R9", "no sync after unlocked realign",
          int'(frameSync), 0);
    @(posedge frameSync);

    // R7: free-run off while unlocked suppresses the next frame's sync
    expectSync(7680, 640, 12, "R7");
    repeat (20) @(negedge clk);
    freeRun  = 1'b0;
    highCnt  = 0;
    riseSeen = 0;
    repeat (7600) begin
      @(negedge clk);
      if (frameSync) highCnt++;
      if (bitRise) riseSeen++;
    end
    check(highCnt == 0, "R7", "sync held low cycles", highCnt, 0);
    check(riseSeen > 0, "R7", "bit clock still running", int'(riseSeen > 0), 1);
    netLock = 1'b1;
    @(posedge frameSync);
    repeat (30) @(negedge clk);
    check(expQ.size() == 0, "R4", "pending expected syncs", expQ.size(), 0);
    finishRun();
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule